// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge

This block conditions the two 32-bit source operands of an arithmetic unit and writes the unit's result back into part of a destination register. For each source it picks a byte, a half-word or the whole word. A picked sub-word field is widened to 32 bits, either with zeros or with copies of its own top bit. On the destination side the low bits of the operation result go into a chosen byte or half-word of the destination. The destination bits outside that field are then filled under one of three policies: cleared, sign-filled, or kept from the old destination value.

The block has no storage and no clock. The arithmetic unit sits between the conditioned operands and the result input, and the surrounding pipeline registers the merged word.

Top module: `sdw_operand_unit`

## Requirements
- R1: Select code 0, 1, 2 or 3 takes byte bits [7:0], [15:8], [23:16] or [31:24]. Code 4 takes half-word bits [15:0] and code 5 takes bits [31:16]. With its sign flag clear, the taken field appears right-aligned on the operand output, with zeros above it.
- R2: Select code 6 means the whole word. Code 7 behaves exactly like code 6, for both sources and for the destination.
- R3: With its sign flag set and a byte or half-word select, a source's operand output carries the taken field with every bit above it equal to the field's top bit.
- R4: With a whole-word select, the sign flag has no effect and the operand output equals the source input.
- R5: For a byte or half-word destination select, the low 8 or 16 result bits appear in the selected destination field, shifted to that field's position.
- R6: Fill code 0 clears every destination bit outside the selected field.
- R7: Fill code 1 sets every destination bit above the field to the result's bit at the field's top (bit 7 or bit 15), and clears every bit below the field.
- R8: Fill code 2 keeps the old destination value in every bit outside the field. Fill code 3 behaves exactly like code 2.
- R9: With a whole-word destination select, the merged word equals the operation result, whatever the fill code.
- R10: Each source path depends only on its own operand, select and sign flag. Changing one source leaves the other operand output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src0_i | input | 32 | First source operand |
| src1_i | input | 32 | Second source operand |
| src0_sel_i | input | 3 | Field select for the first source |
| src1_sel_i | input | 3 | Field select for the second source |
| src0_sext_i | input | 1 | Sign-widen the first source field |
| src1_sext_i | input | 1 | Sign-widen the second source field |
| dst_old_i | input | 32 | Current destination register value |
| op_result_i | input | 32 | Result from the arithmetic unit |
| dst_sel_i | input | 3 | Destination field select |
| dst_fill_i | input | 2 | Policy for destination bits outside the field |
| opnd0_o | output | 32 | Conditioned first operand |
| opnd1_o | output | 32 | Conditioned second operand |
| dst_o | output | 32 | Merged destination word |

## Verification
The embedded checks are immediate and are evaluated whenever the combinational logic settles. They therefore assume that every input is a defined two-state value and that related inputs change together, not through a chain of partial updates. Every 3-bit select and 2-bit fill value, including the two reserved ones, has a defined meaning, so no input combination is excluded. The stimulus changes all inputs in one step at a clock edge. It sweeps every select, sign-flag and fill combination, using random data words whose high field bits are set in some cases and clear in others.

// File: rtl/sdw_pkg.sv
// Shared encodings for the sub-dword operand unit.
// Assumes a data word made of four bytes and two half-words.
package sdw_pkg;
    typedef enum logic [2:0] {
        SEL_BYTE0 = 3'd0,
        SEL_BYTE1 = 3'd1,
        SEL_BYTE2 = 3'd2,
        SEL_BYTE3 = 3'd3,
        SEL_HALF0 = 3'd4,
        SEL_HALF1 = 3'd5,
        SEL_WORD  = 3'd6,
        SEL_ALIAS = 3'd7
    } field_sel_e;

    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_SIGN  = 2'd1,
        FILL_KEEP  = 2'd2,
        FILL_ALIAS = 2'd3
    } fill_pol_e;
endpackage

// File: rtl/sdw_src_extract.sv
// Source field extractor: takes a byte, a half-word or the whole word
// from one operand and widens a sub-word field with zeros or with its sign.
// Assumes DATA_W is divisible by four. Purely combinational.
module sdw_src_extract
    import sdw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_i,
    input  logic [2:0]        sel_i,
    input  logic              sext_i,
    output logic [DATA_W-1:0] op_o
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;

    logic [BYTE_W-1:0] byte_f;
    logic [HALF_W-1:0] half_f;
    field_sel_e        sel;

    // Pick the candidate byte and half-word addressed by the select code.
    always_comb begin
        sel    = field_sel_e'(sel_i);
        byte_f = op_i[int'(sel_i[1:0]) * BYTE_W +: BYTE_W];
        half_f = op_i[int'(sel_i[0]) * HALF_W +: HALF_W];
    end

    // Widen the selected field, or pass the full word through.
    always_comb begin
        case (sel)
            SEL_BYTE0, SEL_BYTE1, SEL_BYTE2, SEL_BYTE3:
                op_o = {{(DATA_W-BYTE_W){sext_i & byte_f[BYTE_W-1]}}, byte_f};
            SEL_HALF0, SEL_HALF1:
                op_o = {{(DATA_W-HALF_W){sext_i & half_f[HALF_W-1]}}, half_f};
            default:
                op_o = op_i;
        endcase
    end

    // Embedded checks on the widened operand.
    always_comb begin
        // R4
        word_pass_chk: assert (!(sel_i >= 3'd6) || op_o == op_i)
            else $error("whole-word select altered the operand");
        // R1
        zext_byte_chk: assert (!(sel_i < 3'd4 && !sext_i) || op_o[DATA_W-1:BYTE_W] == '0)
            else $error("zero-widened byte has nonzero upper bits");
        // R3
        sext_byte_chk: assert (!(sel_i < 3'd4 && sext_i) ||
                               (&op_o[DATA_W-1:BYTE_W-1]) || !(|op_o[DATA_W-1:BYTE_W-1]))
            else $error("sign-widened byte has mixed upper bits");
    end
endmodule

// File: rtl/sdw_dst_merge.sv
// Destination merger: places the low bits of a result into a byte or
// half-word field of the destination and fills the remaining bits by policy.
// Assumes DATA_W is divisible by four. Purely combinational.
module sdw_dst_merge
    import sdw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [2:0]        sel_i,
    input  logic [1:0]        fill_i,
    output logic [DATA_W-1:0] dst_o
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] low_m;
    logic [DATA_W-1:0] field_m;
    logic [DATA_W-1:0] below_m;
    logic [DATA_W-1:0] above_m;
    logic [DATA_W-1:0] placed;
    logic              top_bit;
    logic              sub_sel;
    int                lo;
    fill_pol_e         pol;

    // Decode the field position, its masks and the sign bit of the result.
    always_comb begin
        sub_sel = 1'b1;
        case (field_sel_e'(sel_i))
            SEL_BYTE0, SEL_BYTE1, SEL_BYTE2, SEL_BYTE3: begin
                lo    = int'(sel_i[1:0]) * BYTE_W;
                low_m = (ONE << BYTE_W) - ONE;
            end
            SEL_HALF0, SEL_HALF1: begin
                lo    = int'(sel_i[0]) * HALF_W;
                low_m = (ONE << HALF_W) - ONE;
            end
            default: begin
                lo      = 0;
                low_m   = '1;
                sub_sel = 1'b0;
            end
        endcase
        field_m = low_m << lo;
        below_m = (ONE << lo) - ONE;
        above_m = ~(field_m | below_m);
        placed  = (res_i & low_m) << lo;
        top_bit = |(res_i & low_m & ~(low_m >> 1));
    end

    // Merge the placed field with the fill chosen by the policy code.
    always_comb begin
        pol = fill_pol_e'(fill_i);
        if (!sub_sel) begin
            dst_o = res_i;
        end else begin
            case (pol)
                FILL_ZERO: dst_o = placed;
                FILL_SIGN: dst_o = placed | (top_bit ? above_m : '0);
                default:   dst_o = placed | (old_i & ~field_m);
            endcase
        end
    end

    // Embedded checks on the merged word.
    always_comb begin
        // R9
        word_dst_chk: assert (!(sel_i >= 3'd6) || dst_o == res_i)
            else $error("whole-word destination differs from result");
        // R6
        pad_count_chk: assert (!(sel_i < 3'd4 && fill_i == 2'd0) ||
                               $countones(dst_o) <= BYTE_W)
            else $error("zero fill left bits outside a byte field");
        // R8
        keep_low_chk: assert (!(sel_i != 3'd0 && sel_i != 3'd4 && sel_i < 3'd6 && fill_i[1]) ||
                              dst_o[BYTE_W-1:0] == old_i[BYTE_W-1:0])
            else $error("keep fill changed the lowest byte");
        // R7
        sign_low_chk: assert (!(sel_i != 3'd0 && sel_i != 3'd4 && sel_i < 3'd6 && fill_i == 2'd1) ||
                              dst_o[BYTE_W-1:0] == '0)
            else $error("sign fill left bits below the field");
    end
endmodule

// File: rtl/sdw_operand_unit.sv
// Sub-dword operand unit: conditions two source operands and merges the
// operation result into the destination. No storage and no clock; the
// surrounding pipeline registers the inputs and the outputs.
module sdw_operand_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src0_i,
    input  logic [DATA_W-1:0] src1_i,
    input  logic [2:0]        src0_sel_i,
    input  logic [2:0]        src1_sel_i,
    input  logic              src0_sext_i,
    input  logic              src1_sext_i,
    input  logic [DATA_W-1:0] dst_old_i,
    input  logic [DATA_W-1:0] op_result_i,
    input  logic [2:0]        dst_sel_i,
    input  logic [1:0]        dst_fill_i,
    output logic [DATA_W-1:0] opnd0_o,
    output logic [DATA_W-1:0] opnd1_o,
    output logic [DATA_W-1:0] dst_o
);
    localparam int NUM_SRC = 2;

    logic [DATA_W-1:0] src_a  [NUM_SRC];
    logic [2:0]        sel_a  [NUM_SRC];
    logic              sext_a [NUM_SRC];
    logic [DATA_W-1:0] opnd_a [NUM_SRC];

    // Gather the per-source controls into arrays for the replicated paths.
    always_comb begin
        src_a[0]  = src0_i;
        src_a[1]  = src1_i;
        sel_a[0]  = src0_sel_i;
        sel_a[1]  = src1_sel_i;
        sext_a[0] = src0_sext_i;
        sext_a[1] = src1_sext_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        sdw_src_extract #(.DATA_W(DATA_W)) u_ext (
            .op_i   (src_a[g]),
            .sel_i  (sel_a[g]),
            .sext_i (sext_a[g]),
            .op_o   (opnd_a[g])
        );
    end

    assign opnd0_o = opnd_a[0];
    assign opnd1_o = opnd_a[1];

    sdw_dst_merge #(.DATA_W(DATA_W)) u_merge (
        .old_i  (dst_old_i),
        .res_i  (op_result_i),
        .sel_i  (dst_sel_i),
        .fill_i (dst_fill_i),
        .dst_o  (dst_o)
    );
endmodule

// File: tb/sim_sdw_operand_unit.sv
// Bench for the sub-dword operand unit: directed corner cases followed by
// a sweep of all code combinations with random data from a fixed seed.
module sim_sdw_operand_unit;
    logic        clk = 1'b0;
    logic [31:0] src0, src1, old_v, res_v;
    logic [2:0]  s0sel, s1sel, dsel;
    logic        sx0, sx1;
    logic [1:0]  fill;
    logic [31:0] opnd0, opnd1, dst;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sdw_operand_unit u0 (
        .src0_i(src0), .src1_i(src1), .src0_sel_i(s0sel), .src1_sel_i(s1sel),
        .src0_sext_i(sx0), .src1_sext_i(sx1), .dst_old_i(old_v),
        .op_result_i(res_v), .dst_sel_i(dsel), .dst_fill_i(fill),
        .opnd0_o(opnd0), .opnd1_o(opnd1), .dst_o(dst)
    );

    // Expected conditioned operand.
    function automatic logic [31:0] exp_src(input logic [31:0] v, input logic [2:0] s, input logic x);
        logic [31:0] f;
        int w;
        if (s < 3'd4) begin
            f = (v >> (8 * int'(s))) & 32'hFF;  w = 8;
        end else if (s < 3'd6) begin
            f = (v >> (16 * (int'(s) - 4))) & 32'hFFFF;  w = 16;
        end else return v;
        if (x && f[w-1]) f = f | ~((32'h1 << w) - 32'h1);
        return f;
    endfunction

    // Expected merged destination.
    function automatic logic [31:0] exp_dst(input logic [31:0] o, input logic [31:0] r,
                                            input logic [2:0] s, input logic [1:0] p);
        logic [63:0] lm, fm, v, up;
        int lo, w;
        if (s >= 3'd6) return r;
        if (s < 3'd4) begin lo = 8 * int'(s); w = 8; end
        else begin lo = 16 * (int'(s) - 4); w = 16; end
        lm = (64'h1 << w) - 64'h1;
        fm = lm << lo;
        v  = ({32'h0, r} & lm) << lo;
        up = ~((64'h1 << (lo + w)) - 64'h1) & 64'hFFFF_FFFF;
        if (p == 2'd1 && r[w-1]) v = v | up;
        if (p[1]) v = v | ({32'h0, o} & ~fm);
        return v[31:0];
    endfunction

    function automatic string src_tag(input logic [2:0] s, input logic x);
        if (s == 3'd7) return "R2";
        if (s == 3'd6) return "R4";
        return x ? "R3" : "R1";
    endfunction

    function automatic string dst_tag(input logic [2:0] s, input logic [1:0] p);
        if (s == 3'd7) return "R2";
        if (s == 3'd6) return "R9";
        if (p == 2'd0) return "R6";
        if (p == 2'd1) return "R7";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Drive all inputs at a rising edge, sample at the following falling edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] sa,
                         input logic [2:0] sb, input logic xa, input logic xb,
                         input logic [31:0] o, input logic [31:0] r,
                         input logic [2:0] sd, input logic [1:0] p);
        @(posedge clk);
        src0 = a; src1 = b; s0sel = sa; s1sel = sb; sx0 = xa; sx1 = xb;
        old_v = o; res_v = r; dsel = sd; fill = p;
        @(negedge clk);
    endtask

    task automatic check_all;
        check(src_tag(s0sel, sx0), opnd0, exp_src(src0, s0sel, sx0));
        check(src_tag(s1sel, sx1), opnd1, exp_src(src1, s1sel, sx1));
        check(dst_tag(dsel, fill), dst, exp_dst(old_v, res_v, dsel, fill));
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep0;
        void'($urandom(32'd1234));
        // R1 and R3: byte 1 of a negative-looking byte, zero then sign widened
        apply(32'h0000_8000, 32'h0000_0080, 3'd1, 3'd0, 1'b0, 1'b1,
              32'h0, 32'h0, 3'd6, 2'd0);
        check("R1", opnd0, 32'h0000_0080);
        check("R3", opnd1, 32'hFFFF_FF80);
        // R4: sign flag with a whole-word select
        apply(32'h8765_4321, 32'hF000_0000, 3'd6, 3'd6, 1'b1, 1'b1,
              32'h0, 32'h0, 3'd6, 2'd1);
        check("R4", opnd0, 32'h8765_4321);
        // R2: code 7 on a source and on the destination
        apply(32'hDEAD_BEEF, 32'h0, 3'd7, 3'd5, 1'b1, 1'b1,
              32'h1111_1111, 32'hCAFE_F00D, 3'd7, 2'd0);
        check("R2", opnd0, 32'hDEAD_BEEF);
        check("R2", dst, 32'hCAFE_F00D);
        // R5: low result byte lands in byte 1
        apply(32'h0, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0,
              32'h0, 32'h1234_56AB, 3'd1, 3'd2);
        check("R5", dst, 32'h0000_AB00);
        // R7: sign fill above byte 1, zeros below
        apply(32'h0, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0,
              32'hFFFF_FFFF, 32'h0000_0080, 3'd1, 2'd1);
        check("R7", dst, 32'hFFFF_8000);
        // R7: upper half-word has nothing above it
        apply(32'h0, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0,
              32'hFFFF_FFFF, 32'h0000_8001, 3'd5, 2'd1);
        check("R7", dst, 32'h8001_0000);
        // R8: fill code 3 keeps the old bits
        apply(32'h0, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0,
              32'h1234_5678, 32'h0000_00CD, 3'd0, 2'd3);
        check("R8", dst, 32'h1234_56CD);
        // R6: zero fill around half-word 0
        apply(32'h0, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0,
              32'hFFFF_FFFF, 32'hAAAA_BBBB, 3'd4, 2'd0);
        check("R6", dst, 32'h0000_BBBB);
        // R9: whole-word destination ignores keep fill
        apply(32'h0, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0,
              32'hFFFF_FFFF, 32'h0000_0001, 3'd6, 2'd2);
        check("R9", dst, 32'h0000_0001);
        // R10: change only the second source; the first output must hold
        apply(32'h0000_00F0, 32'h1111_1111, 3'd0, 3'd0, 1'b1, 1'b0,
              32'h0, 32'h0, 3'd6, 2'd0);
        keep0 = opnd0;
        apply(32'h0000_00F0, 32'hFFFF_FFFF, 3'd0, 3'd5, 1'b1, 1'b1,
              32'h0, 32'h0, 3'd6, 2'd0);
        check("R10", opnd0, keep0);
        check("R10", opnd0, 32'hFFFF_FFF0);
        // Sweep of every code combination with random data
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int d = 0; d < 8; d++) begin
                    for (int p = 0; p < 4; p++) begin
                        for (int x = 0; x < 4; x++) begin
                            apply($urandom, $urandom, 3'(a), 3'(b), x[0], x[1],
                                  $urandom, $urandom, 3'(d), 2'(p));
                            check_all();
                        end
                    end
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule